// File: doc/BRIEF.md
# Video Timing Event Code Inserter

This block sits at the output of a 4:2:2 video port and folds the port's timing into the data stream. The receiver needs no separate sync wires. Each output word carries one chroma byte and one luma byte. The source offers one sample per word, together with these flags:

- an active-video level;
- a first-sample-of-line strobe, plus a flag that says whether that line carries picture;
- a first-sample-of-field strobe, plus a parity bit.

When a sample carries one or more timing events, the block holds the source with `in_ready` low. For each event it writes two words: a marker word and then a code word. After that it writes the sample itself. Luma values that would look like the marker are clipped, so a receiver that sees the marker in the luma slot always knows a code follows.

Each code refers to a particular pixel. End of active video refers to the pixel already sent. Start of active video refers to the pixel that follows. The line and field codes refer to the sample they precede.

Top module: `vtc_code_insert`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_c`/`out_y` are 0. The previous-sample active flag resets to 0.
- R2: A sample accepted while `in_ready` is 1 appears on `out_c`/`out_y` on the next clock edge with `out_valid` 1. Its chroma is unchanged.
- R3: In data words, a luma value of FFh is output as FEh. All other luma values pass unchanged.
- R4: Each event produces two words on consecutive cycles. The first is the marker word (chroma 80h, luma FFh). The second is the code word (chroma 80h, luma = the event code).
- R5: When an accepted sample has `in_act` 1 and the previous accepted sample had `in_act` 0, code 02h is sent just before that sample.
- R6: When an accepted sample has `in_act` 0 and the previous accepted sample had `in_act` 1, code 01h is sent just before that sample, and so right after the last active pixel.
- R7: A sample with `in_line` 1 is preceded by code 03h if `in_line_act` is 1, or code 04h if `in_line_act` is 0.
- R8: A sample with `in_field` 1 is preceded by code 06h if `in_odd` is 1, or code 05h if `in_odd` is 0.
- R9: Events that fall on the same sample are sent in this fixed order: active-end, field, line, active-begin. Each event has its own marker.
- R10: For a sample with k events, `in_ready` is 0 for exactly 2k cycles before the sample is taken. k is never more than 3, so `in_ready` is never low for more than 6 cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_c | input | 8 | Chroma byte of the offered sample |
| in_y | input | 8 | Luma byte of the offered sample |
| in_act | input | 1 | Sample lies in active video |
| in_line | input | 1 | Sample is the first of a line |
| in_line_act | input | 1 | The line that starts here carries picture |
| in_field | input | 1 | Sample is the first of a field |
| in_odd | input | 1 | Field parity for `in_field` (1 = odd) |
| in_ready | output | 1 | Offered sample is taken at this clock edge |
| out_valid | output | 1 | Output word valid (1 in every cycle after reset) |
| out_c | output | 8 | Chroma slot of the output word |
| out_y | output | 8 | Luma slot of the output word |

## Verification
The assertions assume that the source keeps the offered sample and all its flags stable while `in_ready` is low, and that it never asks for active-begin and active-end on the same sample. The bench changes its inputs only at the falling edge after it has seen `in_ready` high. It derives the event set from its own record of the previous sample's active flag, so both assumptions hold. The stimulus covers single events, the two largest coincident groups, and luma and chroma values at FFh.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  parameter int DW   = 8;
  parameter int N_EV = 4;
  localparam int EVW = $clog2(N_EV);

  // event slots, in emission order
  localparam int EV_END   = 0;
  localparam int EV_FIELD = 1;
  localparam int EV_LINE  = 2;
  localparam int EV_BEGIN = 3;

  localparam logic [DW-1:0] MARK_W  = {DW{1'b1}};
  localparam logic [DW-1:0] BLANK_C = DW'(1) << (DW-1);

  function automatic logic [DW-1:0] clip_luma(input logic [DW-1:0] y);
    return (y == MARK_W) ? MARK_W - DW'(1) : y;
  endfunction

  function automatic logic [DW-1:0] event_code(input logic [EVW-1:0] idx,
                                               input logic odd,
                                               input logic line_act);
    logic [DW-1:0] c;
    case (idx)
      EVW'(EV_END):   c = DW'(8'h01);
      EVW'(EV_FIELD): c = odd ? DW'(8'h06) : DW'(8'h05);
      EVW'(EV_LINE):  c = line_act ? DW'(8'h03) : DW'(8'h04);
      default:        c = DW'(8'h02);
    endcase
    return c;
  endfunction
endpackage

// File: rtl/vtc_event_detect.sv
module vtc_event_detect
  import vtc_pkg::*;
(
  input  logic            act,
  input  logic            prev_act,
  input  logic            line_start,
  input  logic            field_start,
  output logic [N_EV-1:0] ev
);
  always_comb begin
    ev           = '0;
    ev[EV_END]   = prev_act & ~act;
    ev[EV_FIELD] = field_start;
    ev[EV_LINE]  = line_start;
    ev[EV_BEGIN] = act & ~prev_act;
  end
endmodule

// File: rtl/vtc_pick.sv
module vtc_pick
  import vtc_pkg::*;
(
  input  logic [N_EV-1:0] pend,
  output logic [N_EV-1:0] sel_oh,
  output logic [EVW-1:0]  sel_idx,
  output logic            any
);
  logic [N_EV:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_EV; i++) begin : g_pri
    assign sel_oh[i]  = pend[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | pend[i];
  end

  assign any = seen[N_EV];

  always_comb begin
    sel_idx = '0;
    for (int i = N_EV-1; i >= 0; i--)
      if (sel_oh[i]) sel_idx = EVW'(i);
  end
endmodule

// File: rtl/vtc_code_insert.sv
module vtc_code_insert
  import vtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_c,
  input  logic [DW-1:0] in_y,
  input  logic          in_act,
  input  logic          in_line,
  input  logic          in_line_act,
  input  logic          in_field,
  input  logic          in_odd,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_c,
  output logic [DW-1:0] out_y
);
  localparam int MAX_STALL = 2 * N_EV;
  localparam int SCW       = $clog2(MAX_STALL + 2);

  logic            prev_act_q;
  logic [N_EV-1:0] done_q;
  logic            mark_q;
  logic            is_data_q, is_mark_q, is_code_q;

  logic [N_EV-1:0] ev, pend, sel_oh;
  logic [EVW-1:0]  sel_idx;
  logic            any_pend;
  logic            emit_data, emit_mark, emit_code;

  vtc_event_detect u_det (
    .act         (in_act),
    .prev_act    (prev_act_q),
    .line_start  (in_line),
    .field_start (in_field),
    .ev          (ev)
  );

  assign pend = ev & ~done_q;

  vtc_pick u_pick (
    .pend    (pend),
    .sel_oh  (sel_oh),
    .sel_idx (sel_idx),
    .any     (any_pend)
  );

  assign emit_data = ~any_pend;
  assign emit_mark = any_pend & ~mark_q;
  assign emit_code = any_pend & mark_q;
  assign in_ready  = emit_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_act_q <= 1'b0;
      done_q     <= '0;
      mark_q     <= 1'b0;
      out_valid  <= 1'b0;
      out_c      <= '0;
      out_y      <= '0;
      is_data_q  <= 1'b0;
      is_mark_q  <= 1'b0;
      is_code_q  <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      is_data_q <= emit_data;
      is_mark_q <= emit_mark;
      is_code_q <= emit_code;
      if (emit_data) begin
        out_c      <= in_c;
        out_y      <= clip_luma(in_y);
        prev_act_q <= in_act;
        done_q     <= '0;
        mark_q     <= 1'b0;
      end else if (emit_mark) begin
        out_c  <= BLANK_C;
        out_y  <= MARK_W;
        mark_q <= 1'b1;
      end else begin
        out_c  <= BLANK_C;
        out_y  <= event_code(sel_idx, in_odd, in_line_act);
        done_q <= done_q | sel_oh;
        mark_q <= 1'b0;
      end
    end
  end

  // stall window counter for the R10 bound
  logic [SCW-1:0] stall_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)         stall_cnt <= '0;
    else if (in_ready)  stall_cnt <= '0;
    else                stall_cnt <= stall_cnt + SCW'(1);
  end

  assert_code_after_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_mark_q) |=> (is_code_q && out_y >= DW'(1) && out_y <= DW'(6)));

  assert_blank_chroma_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_data_q) |-> (out_c == BLANK_C));

  assert_no_marker_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_data_q) |-> (out_y != MARK_W));

  assert_stall_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= SCW'(MAX_STALL));

  assert_single_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

  assert_src_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(in_y) && $stable(in_c) && $stable(in_act) && $stable(in_field)));
endmodule

// File: tb/sim_vtc_code_insert.sv
module sim_vtc_code_insert;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_c = '0, in_y = '0;
  logic in_act = 0, in_line = 0, in_line_act = 0, in_field = 0, in_odd = 0;
  logic in_ready, out_valid;
  logic [7:0] out_c, out_y;

  always #2 clk = ~clk;

  vtc_code_insert u0 (
    .clk(clk), .rst_n(rst_n), .in_c(in_c), .in_y(in_y), .in_act(in_act),
    .in_line(in_line), .in_line_act(in_line_act), .in_field(in_field),
    .in_odd(in_odd), .in_ready(in_ready), .out_valid(out_valid),
    .out_c(out_c), .out_y(out_y));

  typedef struct { logic [7:0] c; logic [7:0] y; string tag; } word_t;
  word_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit mon_en = 1'b0;
  bit m_act = 1'b0;

  task automatic check(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic push_event(input logic [7:0] code, input string tag);
    word_t w;
    w.c = 8'h80; w.y = 8'hFF; w.tag = "R4 marker"; exp_q.push_back(w);
    w.c = 8'h80; w.y = code;  w.tag = tag;         exp_q.push_back(w);
  endtask

  // offer one sample; expected words come from the requirements
  task automatic send(input logic [7:0] c, input logic [7:0] y, input bit act,
                      input bit ln, input bit lact, input bit fld, input bit odd);
    int k = 0;
    int stalls = 0;
    word_t w;
    if (m_act && !act) begin push_event(8'h01, "R6/R9 end"); k++; end
    if (fld) begin push_event(odd ? 8'h06 : 8'h05, "R8/R9 field"); k++; end
    if (ln)  begin push_event(lact ? 8'h03 : 8'h04, "R7/R9 line"); k++; end
    if (act && !m_act) begin push_event(8'h02, "R5/R9 begin"); k++; end
    w.c = c; w.y = (y == 8'hFF) ? 8'hFE : y;
    w.tag = (y == 8'hFF) ? "R3 clip" : "R2 data";
    exp_q.push_back(w);
    m_act = act;
    in_c = c; in_y = y; in_act = act; in_line = ln; in_line_act = lact;
    in_field = fld; in_odd = odd;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    check(stalls == 2*k, "R10", $sformatf("stall cycles act=%0d exp=%0d", stalls, 2*k));
    @(negedge clk);
  endtask

  // monitor: pop and compare each produced word
  always @(posedge clk) begin
    #1;
    if (mon_en && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", $sformatf("unexpected word act=%h/%h exp=none", out_c, out_y));
      end else begin
        word_t e;
        e = exp_q.pop_front();
        check(out_c == e.c && out_y == e.y, e.tag,
              $sformatf("act=%h/%h exp=%h/%h", out_c, out_y, e.c, e.y));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && out_y == 8'h00 && out_c == 8'h00, "R1",
          $sformatf("reset act=%b/%h/%h exp=0/00/00", out_valid, out_c, out_y));
    rst_n = 1'b1;
    mon_en = 1'b1;
    // odd field, active line, blanking part
    send(8'h11, 8'h22, 0, 1, 1, 1, 1);
    send(8'h80, 8'h10, 0, 0, 0, 0, 0);
    send(8'h80, 8'h10, 0, 0, 0, 0, 0);
    // active run with marker-valued bytes
    send(8'h40, 8'hFF, 1, 0, 0, 0, 0);
    send(8'h55, 8'h33, 1, 0, 0, 0, 0);
    send(8'hFF, 8'hFF, 1, 0, 0, 0, 0);
    send(8'h66, 8'hFE, 1, 0, 0, 0, 0);
    // end of active
    send(8'h80, 8'h10, 0, 0, 0, 0, 0);
    // blank line
    send(8'h80, 8'h10, 0, 1, 0, 0, 0);
    send(8'h80, 8'h10, 0, 0, 0, 0, 0);
    // even field + active line + begin on one sample
    send(8'h12, 8'h34, 1, 1, 1, 1, 0);
    send(8'h56, 8'h78, 1, 0, 0, 0, 0);
    // end + odd field + blank line on one sample
    send(8'h80, 8'h10, 0, 1, 0, 1, 1);
    // active line starting with active video
    send(8'h9A, 8'hBC, 1, 1, 1, 0, 0);
    send(8'h80, 8'h00, 0, 0, 0, 0, 0);
    while (exp_q.size() != 0) @(negedge clk);
    mon_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule